// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block tells a DDR2-style SDRAM command arbiter when a REFRESH is due. Each retention period the memory needs 8,192 REFRESH commands. That is one every 7.8125 µs on average for the standard temperature grade (64 ms retention) and about one every 3.9 µs for the extended grade (32 ms retention). The block counts controller clocks against the average interval in clock cycles for the selected grade. Each time that interval ends, it adds one to a count of refreshes owed.

While anything is owed and the tRFC recovery window is not running, the block raises a request to the arbiter. The arbiter acknowledges once for each REFRESH it issues. The arbiter may postpone refreshes while the count builds up, then pay them off back to back; each acknowledge clears exactly one. When the count reaches its ceiling of eight, an urgent output tells the arbiter that no more postponement is allowed. An acknowledge that arrives when nothing is owed is discarded and reported on a one-cycle flag.

The intervals and tRFC arrive on input ports as clock counts. The grade input is read only when the interval counter reloads. Issuing the command, closing open banks and self-refresh belong to other blocks.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_o`, `urgent_o` and `stray_o` are 0 and `owed_o` is 0.
- R2: With `ext_grade_i` = 0 and `intv_std_i` = N, `owed_o` first rises to 1 after the (N+1)-th rising clock edge following reset release. It then rises by one every N edges.
- R3: `ext_grade_i` (0 = standard, 1 = extended, period taken from `intv_ext_i`) is sampled only when the interval counter reloads. A change mid-interval does not shorten the interval already running; the next interval uses the new grade.
- R4: `owed_o` saturates at 8. `urgent_o` is 1 exactly while `owed_o` is 8.
- R5: `req_o` is 1 when `owed_o` is non-zero and no tRFC window is running. It is 0 otherwise.
- R6: An acknowledge while `owed_o` is non-zero lowers `owed_o` by one on the next edge. If an interval expires on the same edge, `owed_o` stays unchanged.
- R7: An acknowledge while `owed_o` is 0 leaves `owed_o` at 0 and starts no tRFC window. It raises `stray_o` for exactly the next cycle.
- R8: After an accepted acknowledge with `trfc_i` = T > 0, `req_o` stays 0 for the T cycles that follow the acknowledge edge. It may return on the cycle after that.
- R9: With `trfc_i` = 0, `req_o` stays 1 across back-to-back acknowledges until `owed_o` reaches 0, so a backlog drains one REFRESH per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_grade_i | input | 1 | Retention grade: 0 standard, 1 extended |
| intv_std_i | input | IW | Average refresh interval in clocks, standard grade (at least 1) |
| intv_ext_i | input | IW | Average refresh interval in clocks, extended grade (at least 1) |
| trfc_i | input | TW | Clocks to hold the request low after an accepted acknowledge |
| ack_i | input | 1 | REFRESH issued by the arbiter this cycle |
| req_o | output | 1 | Refresh wanted |
| urgent_o | output | 1 | Owed count at its ceiling |
| stray_o | output | 1 | Previous-cycle acknowledge arrived with nothing owed |
| owed_o | output | OW | Refreshes currently owed |

## Verification
The interval counter loads on the first edge after reset, so an increment of `owed_o` lands on edge k·N+1. The bench restarts reset in each scenario and counts edges from the release, sampling on the falling edge just after the edge where a change is due. It also samples the edge before, to confirm the change has not come early. `owed_o`, `stray_o` and the holdoff state all change one edge after an acknowledge. `req_o` and `urgent_o` follow combinationally from those registers, so they are checked at the same falling edge. `req_o` is checked on both sides of the T-th edge after an acknowledge. Acknowledges are placed on edges where no interval expires, except in the scenario that tests the coincidence on purpose.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic {
        GRADE_STD = 1'b0,
        GRADE_EXT = 1'b1
    } grade_e;

    localparam int unsigned OWED_CEIL = 8;

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer
    import refresh_sched_pkg::*;
#(
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grade_i,
    input  logic [IW-1:0] intv_std_i,
    input  logic [IW-1:0] intv_ext_i,
    output logic          tick_o
);

    typedef struct packed {
        logic          armed;
        logic [IW-1:0] cnt;
    } tmr_t;

    tmr_t          st_d, st_q;
    logic [IW-1:0] period;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        period = (grade_e'(grade_i) == GRADE_EXT) ? intv_ext_i : intv_std_i;
        if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.cnt   = period - IW'(1);
        end else if (st_q.cnt == '0) begin
            tick_o   = 1'b1;
            st_d.cnt = period - IW'(1);
        end else begin
            st_d.cnt = st_q.cnt - IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rs_debt_counter.sv
module rs_debt_counter #(
    parameter int unsigned OWED_MAX = 8,
    localparam int unsigned OW      = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          ack_i,
    output logic          take_o,
    output logic          stray_o,
    output logic [OW-1:0] owed_o
);

    typedef struct packed {
        logic [OW-1:0] owed;
        logic          stray;
    } debt_t;

    debt_t st_d, st_q;
    logic  at_ceil;

    always_comb begin
        st_d    = st_q;
        at_ceil = (st_q.owed == OW'(OWED_MAX));
        take_o  = ack_i && (st_q.owed != '0);
        st_d.stray = ack_i && (st_q.owed == '0);
        if (tick_i && !take_o) begin
            if (!at_ceil) st_d.owed = st_q.owed + OW'(1);
        end else if (!tick_i && take_o) begin
            st_d.owed = st_q.owed - OW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owed_o  = st_q.owed;
    assign stray_o = st_q.stray;

endmodule

// File: rtl/rs_holdoff_timer.sv
module rs_holdoff_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [TW-1:0] trfc_i,
    output logic          busy_o
);

    logic [TW-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take_i)              hold_d = trfc_i;
        else if (hold_q != '0)   hold_d = hold_q - TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign busy_o = (hold_q != '0);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int unsigned IW       = 16,
    parameter int unsigned TW       = 8,
    parameter int unsigned OWED_MAX = OWED_CEIL,
    localparam int unsigned OW      = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_grade_i,
    input  logic [IW-1:0] intv_std_i,
    input  logic [IW-1:0] intv_ext_i,
    input  logic [TW-1:0] trfc_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic          urgent_o,
    output logic          stray_o,
    output logic [OW-1:0] owed_o
);

    logic tick, take, busy;

    rs_interval_timer #(.IW(IW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .grade_i    (ext_grade_i),
        .intv_std_i (intv_std_i),
        .intv_ext_i (intv_ext_i),
        .tick_o     (tick)
    );

    rs_debt_counter #(.OWED_MAX(OWED_MAX)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .ack_i   (ack_i),
        .take_o  (take),
        .stray_o (stray_o),
        .owed_o  (owed_o)
    );

    rs_holdoff_timer #(.TW(TW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .trfc_i (trfc_i),
        .busy_o (busy)
    );

    assign req_o    = (owed_o != '0) && !busy;
    assign urgent_o = (owed_o == OW'(OWED_MAX));

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int unsigned TW       = 8,
    parameter int unsigned OWED_MAX = 8,
    localparam int unsigned OW      = $clog2(OWED_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] trfc_i,
    input logic          ack_i,
    input logic          req_o,
    input logic          urgent_o,
    input logic          stray_o,
    input logic [OW-1:0] owed_o
);

    p_owed_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        owed_o <= OW'(OWED_MAX));

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> {1'b0, owed_o} <= {1'b0, $past(owed_o)} + 1'b1);

    p_req_needs_debt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> owed_o != '0);

    p_urgent_keeps_debt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |=> owed_o >= OW'(OWED_MAX - 1));

    p_ack_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && owed_o != '0) |=> owed_o <= $past(owed_o));

    p_stray_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && owed_o == '0) |=> stray_o && owed_o <= OW'(1));

    p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && owed_o != '0 && trfc_i != '0) |=> !req_o);

endmodule

bind refresh_sched refresh_sched_chk #(.TW(TW), .OWED_MAX(OWED_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trfc_i   (trfc_i),
    .ack_i    (ack_i),
    .req_o    (req_o),
    .urgent_o (urgent_o),
    .stray_o  (stray_o),
    .owed_o   (owed_o)
);

// File: tb/test_refresh_sched.sv
`timescale 1ns/1ps
module test_refresh_sched;

    localparam int unsigned IW = 16;
    localparam int unsigned TW = 8;
    localparam int unsigned OW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_grade_i = 1'b0;
    logic [IW-1:0] intv_std_i = 16'd20;
    logic [IW-1:0] intv_ext_i = 16'd10;
    logic [TW-1:0] trfc_i = 8'd3;
    logic          ack_i = 1'b0;
    logic          req_o, urgent_o, stray_o;
    logic [OW-1:0] owed_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    refresh_sched i_refresh_sched (
        .clk(clk), .rst_n(rst_n), .ext_grade_i(ext_grade_i),
        .intv_std_i(intv_std_i), .intv_ext_i(intv_ext_i), .trfc_i(trfc_i),
        .ack_i(ack_i), .req_o(req_o), .urgent_o(urgent_o),
        .stray_o(stray_o), .owed_o(owed_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input logic grade);
        @(negedge clk);
        rst_n = 1'b0;
        ack_i = 1'b0;
        ext_grade_i = grade;
        edges(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_ack;
        ack_i = 1'b1;
        edges(1);
        ack_i = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        edges(2);
        check("R1", "req in reset", int'(req_o), 0);
        check("R1", "owed in reset", int'(owed_o), 0);
        check("R1", "urgent in reset", int'(urgent_o), 0);
        rst_n = 1'b1;
        edges(1);
        check("R1", "req after release", int'(req_o), 0);
        check("R1", "stray after release", int'(stray_o), 0);
    endtask

    task automatic t_interval;
        restart(1'b0);
        edges(20);
        check("R2", "owed before first tick", int'(owed_o), 0);
        edges(1);
        check("R2", "owed after e21", int'(owed_o), 1);
        check("R5", "req with debt", int'(req_o), 1);
        edges(19);
        check("R2", "owed after e40", int'(owed_o), 1);
        edges(1);
        check("R2", "owed after e41", int'(owed_o), 2);
    endtask

    task automatic t_grade;
        restart(1'b0);
        edges(5);
        ext_grade_i = 1'b1;
        edges(15);
        check("R3", "owed after e20", int'(owed_o), 0);
        edges(1);
        check("R3", "owed after e21", int'(owed_o), 1);
        edges(9);
        check("R3", "owed after e30", int'(owed_o), 1);
        edges(1);
        check("R3", "owed after e31", int'(owed_o), 2);
    endtask

    task automatic t_ceiling_and_holdoff;
        trfc_i = 8'd3;
        restart(1'b1);
        edges(80);
        check("R4", "owed after e80", int'(owed_o), 7);
        check("R4", "urgent at 7", int'(urgent_o), 0);
        edges(1);
        check("R4", "owed after e81", int'(owed_o), 8);
        check("R4", "urgent at 8", int'(urgent_o), 1);
        edges(10);
        check("R4", "owed saturated e91", int'(owed_o), 8);
        pulse_ack;
        check("R6", "owed after ack", int'(owed_o), 7);
        check("R4", "urgent cleared", int'(urgent_o), 0);
        check("R8", "req held low at e92", int'(req_o), 0);
        edges(2);
        check("R8", "req held low at e94", int'(req_o), 0);
        edges(1);
        check("R8", "req back at e95", int'(req_o), 1);
        edges(5);
        pulse_ack;
        check("R6", "tick and ack together", int'(owed_o), 7);
    endtask

    task automatic t_stray;
        restart(1'b0);
        edges(4);
        pulse_ack;
        check("R7", "stray raised", int'(stray_o), 1);
        check("R7", "owed stays 0", int'(owed_o), 0);
        edges(1);
        check("R7", "stray one cycle", int'(stray_o), 0);
        edges(15);
        check("R7", "owed after e21", int'(owed_o), 1);
        check("R7", "no holdoff started", int'(req_o), 1);
    endtask

    task automatic t_back_to_back;
        trfc_i = 8'd0;
        restart(1'b1);
        edges(21);
        check("R9", "backlog", int'(owed_o), 2);
        ack_i = 1'b1;
        edges(1);
        check("R9", "owed after first ack", int'(owed_o), 1);
        check("R9", "req stays high", int'(req_o), 1);
        edges(1);
        ack_i = 1'b0;
        check("R9", "owed drained", int'(owed_o), 0);
        check("R9", "req low when drained", int'(req_o), 0);
        check("R9", "no stray", int'(stray_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset;
        t_interval;
        t_grade;
        t_ceiling_and_holdoff;
        t_stray;
        t_back_to_back;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule